// File: doc/BRIEF.md
# Converter Read Sequencer

This block sits on the host side of a 12-bit successive-approximation converter that has a parallel bus. The converter is controlled with active-low chip select and read strobes and a byte-select line. It reports a conversion in progress by holding its busy line low. A one-cycle request to the sequencer runs one complete acquisition. The sequencer issues the read strobes, waits or counts cycles as the selected mode needs, assembles a right-justified 16-bit result and pulses a valid flag.

Two timing modes are offered. In the wait-state mode, the read that starts a conversion is held low until busy returns high, and the fresh data is then taken from that same read. In the no-wait mode, every start read returns stale data from the previous conversion and begins a new one. The new value is fetched by a later read that an internal timer spaces out. Either mode can use the full 12-bit bus or a narrow 8-bit bus. On the narrow bus, a read with byte-select high returns the upper four bits on data lines 3..0, and that read never starts a conversion. All minimum timings are parameters counted in system clock cycles.

Top module: `adc_read_seq`

## Requirements
- R1: While reset is asserted and after it is released, csN and rdN are high, hben is low, resultValid is low and timeoutErr is low.
- R2: With modeRom=0 and modeByte=0, a request produces exactly one read with hben=0. rdN stays low until busyN is seen high. The result is {4'b0, busIn[11:0]} taken at the end of that read, and resultValid is high for exactly one cycle.
- R3: With modeRom=0 and modeByte=1, a request produces a read with hben=0 and then a read with hben=1. The first read captures busIn[7:0] as result bits 7..0 once busyN is high. The second read captures busIn[3:0] as result bits 11..8. Result bits 15..12 are zero. Only the first read starts a conversion.
- R4: With modeRom=1 and modeByte=0, a request produces two reads, both with hben=0. Data from the first read is discarded. The second read supplies the result {4'b0, busIn}. Both reads start conversions.
- R5: With modeRom=1 and modeByte=1, a request produces three reads with hben 0, 1, 0 in that order. The second read falls at least CONV_CYC cycles after the first and supplies result bits 11..8 from busIn[3:0]. The third read supplies bits 7..0 from busIn[7:0] and starts the next conversion.
- R6: hben is held steady for the whole time rdN is low, from the cycle before rdN falls through the cycle in which rdN rises.
- R7: rdN stays high for at least RD_GAP_CYC cycles between two reads.
- R8: Every low pulse on rdN lasts at least RD_LOW_CYC cycles.
- R9: A read with hben=0 falls no sooner than CONV_CYC+ACQ_CYC cycles after the previous read with hben=0. If busyN stays low for TIMEOUT_CYC cycles of a wait-state read, rdN is released, timeoutErr is set and no resultValid is given. timeoutErr clears on the next accepted request.
- R10: A request that arrives while a sequence is running is held. It runs as a separate sequence afterwards, so two requests give exactly two resultValid pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | One-cycle request to run an acquisition |
| modeRom | input | 1 | 1 = no-wait mode, 0 = wait-state mode; sampled when a request is accepted |
| modeByte | input | 1 | 1 = 8-bit bus (two byte reads), 0 = 12-bit bus; sampled with modeRom |
| busyN | input | 1 | Converter busy, low while a conversion runs |
| busIn | input | 12 | Converter data bus |
| csN | output | 1 | Chip select to converter, active low |
| rdN | output | 1 | Read strobe to converter, active low |
| hben | output | 1 | Byte select: 1 selects the upper nibble and blocks a start |
| resultData | output | 16 | Right-justified 12-bit result |
| resultValid | output | 1 | One-cycle pulse when resultData is new |
| timeoutErr | output | 1 | Set when busy did not return in time |

## Verification
The assertions assume that the converter drops busyN no later than the second cycle of a start read. This is why RD_LOW_CYC must be at least 2. They also assume that a conversion finishes within CONV_CYC cycles unless it is deliberately stalled. The bench's converter model meets both assumptions: it begins converting on the first clock edge at which it sees a start read, and its conversion time is shorter than CONV_CYC. A stall switch freezes the model only for the timeout case. Requests are single-cycle pulses, and the mode inputs are held steady until each sequence completes.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

  typedef enum logic [1:0] {S_IDLE, S_ARM, S_READ} seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadConv;
    logic loadGap;
    logic clrPhase;
    logic capLow;
    logic capHigh;
    logic emit;
    logic setErr;
    logic clrErr;
  } seqStrobe_t;

  // what a given read step of a sequence does
  typedef struct packed {
    logic hbenVal;
    logic isStart;
    logic waitBusy;
    logic waitConv;
    logic capLow;
    logic capHigh;
    logic isLast;
  } stepAttr_t;

  function automatic stepAttr_t stepAttr(input logic rom, input logic byteW,
                                         input logic [1:0] step);
    stepAttr_t a;
    a = '0;
    unique case ({rom, byteW})
      2'b00: begin
        a.isStart = 1'b1; a.waitBusy = 1'b1; a.isLast = 1'b1;
      end
      2'b01: begin
        if (step == 2'd0) begin
          a.isStart = 1'b1; a.waitBusy = 1'b1; a.capLow = 1'b1;
        end else begin
          a.hbenVal = 1'b1; a.capHigh = 1'b1; a.isLast = 1'b1;
        end
      end
      2'b10: begin
        a.isStart = 1'b1;
        a.isLast  = (step != 2'd0);
      end
      default: begin
        if (step == 2'd0) begin
          a.isStart = 1'b1;
        end else if (step == 2'd1) begin
          a.hbenVal = 1'b1; a.waitConv = 1'b1; a.capHigh = 1'b1;
        end else begin
          a.isStart = 1'b1; a.capLow = 1'b1; a.isLast = 1'b1;
        end
      end
    endcase
    return a;
  endfunction

endpackage

// File: rtl/adcseq_datapath.sv
module adcseq_datapath
  import adcseq_pkg::*;
#(
  parameter int RD_LOW_CYC  = 3,
  parameter int RD_GAP_CYC  = 25,
  parameter int CONV_CYC    = 24,
  parameter int ACQ_CYC     = 8,
  parameter int TIMEOUT_CYC = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  seqStrobe_t  stb,
  input  logic [11:0] busIn,
  output logic        convZero,
  output logic        convLeAcq,
  output logic        gapZero,
  output logic        lowDone,
  output logic        busyTimeout,
  output logic [15:0] resultData,
  output logic        resultValid,
  output logic        timeoutErr
);

  localparam int CONV_TOT = CONV_CYC + ACQ_CYC;
  localparam int CW       = $clog2(CONV_TOT + 1);
  localparam int GW       = $clog2(RD_GAP_CYC + 1);
  localparam int PMAX     = (TIMEOUT_CYC > RD_LOW_CYC) ? TIMEOUT_CYC : RD_LOW_CYC;
  localparam int PW       = $clog2(PMAX + 1);

  logic [CW-1:0] convTimer;
  logic [GW-1:0] gapTimer;
  logic [PW-1:0] phaseCnt;
  logic [7:0]    lowByte;
  logic [3:0]    highNib;

  assign convZero    = (convTimer == '0);
  assign convLeAcq   = (convTimer <= CW'(ACQ_CYC));
  assign gapZero     = (gapTimer == '0);
  assign lowDone     = (phaseCnt >= PW'(RD_LOW_CYC - 1));
  assign busyTimeout = (phaseCnt >= PW'(TIMEOUT_CYC - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      convTimer   <= '0;
      gapTimer    <= '0;
      phaseCnt    <= '0;
      lowByte     <= '0;
      highNib     <= '0;
      resultData  <= '0;
      resultValid <= 1'b0;
      timeoutErr  <= 1'b0;
    end else begin
      if (stb.loadConv)       convTimer <= CW'(CONV_TOT);
      else if (!convZero)     convTimer <= convTimer - 1'b1;

      if (stb.loadGap)        gapTimer <= GW'(RD_GAP_CYC);
      else if (!gapZero)      gapTimer <= gapTimer - 1'b1;

      if (stb.clrPhase)                 phaseCnt <= '0;
      else if (phaseCnt != PW'(PMAX))   phaseCnt <= phaseCnt + 1'b1;

      if (stb.capLow)  lowByte <= busIn[7:0];
      if (stb.capHigh) highNib <= busIn[3:0];

      resultValid <= stb.emit;
      if (stb.emit) begin
        if (stb.capLow)       resultData <= {4'b0, highNib, busIn[7:0]};
        else if (stb.capHigh) resultData <= {4'b0, busIn[3:0], lowByte};
        else                  resultData <= {4'b0, busIn};
      end

      if (stb.setErr)      timeoutErr <= 1'b1;
      else if (stb.clrErr) timeoutErr <= 1'b0;
    end
  end

  // R2: result valid is a single-cycle pulse
  p_valid_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);

  // R9: an aborted read never reports a result at the same time
  p_err_no_valid_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutErr) |-> !resultValid);

endmodule

// File: rtl/adcseq_ctrl.sv
module adcseq_ctrl
  import adcseq_pkg::*;
#(
  parameter int RD_LOW_CYC  = 3,
  parameter int RD_GAP_CYC  = 25,
  parameter int CONV_CYC    = 24,
  parameter int ACQ_CYC     = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       modeRom,
  input  logic       modeByte,
  input  logic       busyN,
  input  logic       convZero,
  input  logic       convLeAcq,
  input  logic       gapZero,
  input  logic       lowDone,
  input  logic       busyTimeout,
  output seqStrobe_t stb,
  output logic       rdN,
  output logic       hben
);

  seqState_t  state;
  logic [1:0] step;
  logic       romSel, byteSel, reqPending;
  logic       accept, ready, done, abort;
  stepAttr_t  cur;

  assign cur = stepAttr(romSel, byteSel, step);

  always_comb begin
    stb    = '0;
    accept = 1'b0;
    ready  = 1'b0;
    done   = 1'b0;
    abort  = 1'b0;
    unique case (state)
      S_IDLE: begin
        accept     = reqValid || reqPending;
        stb.clrErr = accept;
      end
      S_ARM: begin
        ready = gapZero && (hben == cur.hbenVal) &&
                (!cur.isStart || convZero) && (!cur.waitConv || convLeAcq);
        stb.clrPhase = ready;
        stb.loadConv = ready && cur.isStart;
      end
      S_READ: begin
        done  = lowDone && (!cur.waitBusy || busyN);
        abort = !done && cur.waitBusy && busyTimeout;
        stb.loadGap = done || abort;
        stb.capLow  = done && cur.capLow;
        stb.capHigh = done && cur.capHigh;
        stb.emit    = done && cur.isLast;
        stb.setErr  = abort;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= S_IDLE;
      step       <= '0;
      romSel     <= 1'b0;
      byteSel    <= 1'b0;
      reqPending <= 1'b0;
      rdN        <= 1'b1;
      hben       <= 1'b0;
    end else begin
      reqPending <= (reqPending || reqValid) && !accept;
      unique case (state)
        S_IDLE: if (accept) begin
          state   <= S_ARM;
          step    <= '0;
          romSel  <= modeRom;
          byteSel <= modeByte;
        end
        S_ARM: begin
          hben <= cur.hbenVal;
          if (ready) begin
            state <= S_READ;
            rdN   <= 1'b0;
          end
        end
        S_READ: begin
          if (done) begin
            rdN <= 1'b1;
            if (cur.isLast) state <= S_IDLE;
            else begin
              state <= S_ARM;
              step  <= step + 2'd1;
            end
          end else if (abort) begin
            rdN   <= 1'b1;
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // observation counters for the timing assertions
  localparam int CONV_TOT = CONV_CYC + ACQ_CYC;
  localparam int LW = $clog2(RD_LOW_CYC + 1);
  localparam int HW = $clog2(RD_GAP_CYC + 1);
  localparam int SW = $clog2(CONV_TOT + 1);

  logic [LW-1:0] rdLowLen;
  logic [HW-1:0] rdHighLen;
  logic [SW-1:0] sinceStart;
  logic          rdNd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdLowLen   <= '0;
      rdHighLen  <= HW'(RD_GAP_CYC);
      sinceStart <= SW'(CONV_TOT);
      rdNd       <= 1'b1;
    end else begin
      rdNd <= rdN;
      if (rdN) rdLowLen <= '0;
      else if (rdLowLen != LW'(RD_LOW_CYC)) rdLowLen <= rdLowLen + 1'b1;
      if (!rdN) rdHighLen <= '0;
      else if (rdHighLen != HW'(RD_GAP_CYC)) rdHighLen <= rdHighLen + 1'b1;
      if (rdNd && !rdN && !hben) sinceStart <= SW'(1);
      else if (sinceStart != SW'(CONV_TOT)) sinceStart <= sinceStart + 1'b1;
    end
  end

  // R6: byte select steady around and during a read
  p_hben_steady_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!rdN || !$past(rdN)) |-> $stable(hben));

  // R8: minimum read pulse width
  p_rd_width_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdN) |-> (rdLowLen >= LW'(RD_LOW_CYC)));

  // R7: minimum spacing between reads
  p_rd_gap_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rdN) |-> (rdHighLen >= HW'(RD_GAP_CYC)));

  // R9: spacing between conversion starts
  p_conv_space_r9: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(rdN) && !hben) |-> (sinceStart >= SW'(CONV_TOT)));

endmodule

// File: rtl/adc_read_seq.sv
module adc_read_seq
  import adcseq_pkg::*;
#(
  parameter int RD_LOW_CYC  = 3,
  parameter int RD_GAP_CYC  = 25,
  parameter int CONV_CYC    = 24,
  parameter int ACQ_CYC     = 8,
  parameter int TIMEOUT_CYC = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        modeRom,
  input  logic        modeByte,
  input  logic        busyN,
  input  logic [11:0] busIn,
  output logic        csN,
  output logic        rdN,
  output logic        hben,
  output logic [15:0] resultData,
  output logic        resultValid,
  output logic        timeoutErr
);

  seqStrobe_t stb;
  logic convZero, convLeAcq, gapZero, lowDone, busyTimeout;

  adcseq_ctrl #(
    .RD_LOW_CYC(RD_LOW_CYC), .RD_GAP_CYC(RD_GAP_CYC),
    .CONV_CYC(CONV_CYC), .ACQ_CYC(ACQ_CYC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .modeRom(modeRom),
    .modeByte(modeByte), .busyN(busyN), .convZero(convZero),
    .convLeAcq(convLeAcq), .gapZero(gapZero), .lowDone(lowDone),
    .busyTimeout(busyTimeout), .stb(stb), .rdN(rdN), .hben(hben)
  );

  adcseq_datapath #(
    .RD_LOW_CYC(RD_LOW_CYC), .RD_GAP_CYC(RD_GAP_CYC), .CONV_CYC(CONV_CYC),
    .ACQ_CYC(ACQ_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .busIn(busIn), .convZero(convZero),
    .convLeAcq(convLeAcq), .gapZero(gapZero), .lowDone(lowDone),
    .busyTimeout(busyTimeout), .resultData(resultData),
    .resultValid(resultValid), .timeoutErr(timeoutErr)
  );

  assign csN = rdN;

endmodule

// File: tb/adc_read_seq_tb.sv
module adc_read_seq_tb;

  localparam int RD_LOW   = 3;
  localparam int RD_GAP   = 25;
  localparam int CONV     = 24;
  localparam int ACQ      = 8;
  localparam int TMO      = 64;
  localparam int MODEL_CV = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, modeRom = 1'b0, modeByte = 1'b0;
  logic busyN;
  logic [11:0] busIn;
  logic csN, rdN, hben, resultValid, timeoutErr;
  logic [15:0] resultData;

  // converter model state
  logic [11:0] anaVal = '0;
  logic        stuck = 1'b0;
  logic [11:0] latchOut, pend;
  logic [7:0]  cnt;
  logic        prevRd;
  int          modelStarts;

  int total = 0, bad = 0, cyc = 0;
  bit finished = 1'b0;

  // read monitor
  int rdCount = 0;
  int rdCyc [0:3];
  logic rdHb [0:3];
  logic monPrevRd = 1'b1, monPrevHb = 1'b0;
  int lowRun = 0, minLow = 1000, hbErr = 0;
  logic hbAtFall = 1'b0;

  always #4 clk = ~clk;

  adc_read_seq #(.RD_LOW_CYC(RD_LOW), .RD_GAP_CYC(RD_GAP), .CONV_CYC(CONV),
                 .ACQ_CYC(ACQ), .TIMEOUT_CYC(TMO)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .modeRom(modeRom),
    .modeByte(modeByte), .busyN(busyN), .busIn(busIn), .csN(csN), .rdN(rdN),
    .hben(hben), .resultData(resultData), .resultValid(resultValid),
    .timeoutErr(timeoutErr));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyN <= 1'b1; cnt <= '0; latchOut <= '0; pend <= '0;
      prevRd <= 1'b1; modelStarts <= 0;
    end else begin
      prevRd <= rdN;
      if (!csN && !rdN && !hben && prevRd && busyN) begin
        busyN <= 1'b0; cnt <= 8'(MODEL_CV); pend <= anaVal;
        modelStarts <= modelStarts + 1;
      end else if (!busyN && !stuck) begin
        if (cnt == 8'd1) begin busyN <= 1'b1; latchOut <= pend; end
        else cnt <= cnt - 8'd1;
      end
    end
  end

  assign busIn = (!csN && hben) ? {latchOut[11:8], 4'b0000, latchOut[11:8]} : latchOut;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (monPrevRd && !rdN) begin
      if (rdCount < 4) begin rdCyc[rdCount] = cyc; rdHb[rdCount] = hben; end
      rdCount = rdCount + 1;
      if (hben != monPrevHb) hbErr = hbErr + 1;
      hbAtFall = hben;
    end
    if (!rdN) begin
      lowRun = lowRun + 1;
      if (hben != hbAtFall) hbErr = hbErr + 1;
    end else if (!monPrevRd) begin
      if (hben != hbAtFall) hbErr = hbErr + 1;
      if (lowRun < minLow) minLow = lowRun;
      lowRun = 0;
    end
    monPrevRd = rdN;
    monPrevHb = hben;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int expReads(input logic rom, input logic byt);
    return rom ? (byt ? 3 : 2) : (byt ? 2 : 1);
  endfunction

  function automatic logic expHb(input logic rom, input logic byt, input int idx);
    return byt && (idx == 1);
  endfunction

  function automatic int expStarts(input logic rom, input logic byt);
    return rom ? 2 : 1;
  endfunction

  function automatic string reqTag(input logic rom, input logic byt);
    return rom ? (byt ? "R5" : "R4") : (byt ? "R3" : "R2");
  endfunction

  task automatic pulseReq();
    @(negedge clk); reqValid = 1'b1;
    @(negedge clk); reqValid = 1'b0;
  endtask

  task automatic runSeq(input logic rom, input logic byt, input logic [11:0] ana);
    int n, base;
    string t;
    t = reqTag(rom, byt);
    anaVal = ana; modeRom = rom; modeByte = byt;
    @(posedge clk);
    rdCount = 0; base = modelStarts;
    pulseReq();
    n = 0;
    while (!resultValid && n < 3000) begin @(negedge clk); n++; end
    chk(resultValid, t, int'(resultValid), 1);
    chk(resultData == {4'b0, ana}, t, int'(resultData), int'({4'b0, ana}));
    chk(rdCount == expReads(rom, byt), t, rdCount, expReads(rom, byt));
    for (int i = 0; i < expReads(rom, byt) && i < 4; i++)
      chk(rdHb[i] == expHb(rom, byt, i), t, int'(rdHb[i]), int'(expHb(rom, byt, i)));
    chk(modelStarts - base == expStarts(rom, byt), t, modelStarts - base, expStarts(rom, byt));
    if (rdCount >= 2) begin
      chk(rdCyc[1] - rdCyc[0] >= RD_LOW + RD_GAP, "R7", rdCyc[1] - rdCyc[0], RD_LOW + RD_GAP);
      if (rom && !byt)
        chk(rdCyc[1] - rdCyc[0] >= CONV + ACQ, "R4", rdCyc[1] - rdCyc[0], CONV + ACQ);
    end
    if (rom && byt && rdCount >= 3) begin
      chk(rdCyc[1] - rdCyc[0] >= CONV, "R5", rdCyc[1] - rdCyc[0], CONV);
      chk(rdCyc[2] - rdCyc[0] >= CONV + ACQ, "R9", rdCyc[2] - rdCyc[0], CONV + ACQ);
    end
    chk(!timeoutErr, "R9", int'(timeoutErr), 0);
    @(negedge clk);
    chk(!resultValid, "R2", int'(resultValid), 0);
  endtask

  always @(posedge clk) begin
    if (cyc > 150000 && !finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seedDummy, n, vcount;
    logic [1:0] m;
    seedDummy = $urandom(32'd2718);
    repeat (3) @(negedge clk);
    chk(csN && rdN && !hben && !resultValid && !timeoutErr, "R1", int'({csN, rdN, hben}), 3'b110);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(csN && rdN && !hben && !resultValid && !timeoutErr, "R1", int'({csN, rdN, hben}), 3'b110);

    // directed corner values in every mode
    runSeq(1'b1, 1'b0, 12'h000);
    runSeq(1'b0, 1'b0, 12'hFFF);
    runSeq(1'b0, 1'b1, 12'hA5C);
    runSeq(1'b1, 1'b1, 12'h3F0);
    runSeq(1'b1, 1'b1, 12'hFFF);
    runSeq(1'b0, 1'b1, 12'h000);

    // random mix
    for (int i = 0; i < 40; i++) begin
      m = 2'($urandom_range(3, 0));
      runSeq(m[1], m[0], 12'($urandom_range(4095, 0)));
      repeat ($urandom_range(9, 0)) @(negedge clk);
    end

    // R10: second request during a sequence is held, two results
    anaVal = 12'h5A5; modeRom = 1'b0; modeByte = 1'b0;
    vcount = 0;
    pulseReq();
    repeat (3) @(negedge clk);
    @(negedge clk); reqValid = 1'b1;
    @(negedge clk); reqValid = 1'b0;
    n = 0;
    while (n < 600) begin
      if (resultValid) vcount++;
      @(negedge clk); n++;
    end
    chk(vcount == 2, "R10", vcount, 2);
    chk(resultData == 16'h05A5, "R10", int'(resultData), 16'h05A5);

    // R9: stalled conversion times out
    stuck = 1'b1; anaVal = 12'h777;
    vcount = 0;
    pulseReq();
    n = 0;
    while (!timeoutErr && n < TMO + 200) begin
      if (resultValid) vcount++;
      @(negedge clk); n++;
    end
    chk(timeoutErr, "R9", int'(timeoutErr), 1);
    chk(vcount == 0, "R9", vcount, 0);
    @(negedge clk);
    chk(rdN && csN, "R9", int'(rdN), 1);
    repeat (20) @(negedge clk);
    chk(rdN && !resultValid, "R9", int'(resultValid), 0);
    stuck = 1'b0;
    repeat (40) @(negedge clk);
    pulseReq();
    chk(!timeoutErr, "R9", int'(timeoutErr), 0);
    repeat (200) @(negedge clk);
    chk(resultData == 16'h0777, "R9", int'(resultData), 16'h0777);

    chk(minLow >= RD_LOW, "R8", minLow, RD_LOW);
    chk(hbErr == 0, "R6", hbErr, 0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule